// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Time Registers

This block sits between an 8-bit processor bus with 16-bit addresses and the memories of a plug-in cartridge. The lower half of the address space (0x0000-0x7FFF) is read-only program storage. Writes there cannot reach the storage, so they are decoded as control writes. These writes choose which program bank appears in the upper 16 KiB of that space. They also choose which external RAM bank appears at 0xA000-0xBFFF, gate access to that RAM, and can swap the RAM window for a small file of time registers.

The block holds a running time counter of seconds, minutes, hours and a day count, which advances on a one-cycle tick. A two-write sequence copies the running counter into five registers that the processor can read and write. The program ROM and external RAM arrays sit outside the block. The block drives bank-extended addresses and chip selects for both, and returns read data for the external window.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the program bank is 1, the RAM bank is 0, RAM access is off and time-register mapping is off.
- R2: A control write in 0x0000-0x1FFF with data 0x0A turns RAM access on. Data 0x00 turns it off. Any other data leaves it as it was.
- R3: A control write in 0x2000-0x3FFF sets the program bank to data[6:0], and a value of 0 becomes 1. A read at 0x4000-0x7FFF drives rom_addr = {bank masked to ROM_BANK_BITS (default 5) bits, addr[13:0]}. A read at 0x0000-0x3FFF drives rom_addr = {0, addr[13:0]}.
- R4: A control write in 0x4000-0x5FFF with data below 4 selects that RAM bank and turns time mapping off. External RAM is addressed as ram_addr = {bank, addr[12:0]}.
- R5: A control write in 0x4000-0x5FFF with data 0x08 to 0x0C selects time register data-8 and turns time mapping on. Data 4-7 and above 0x0C changes nothing.
- R6: Accesses at 0xA000-0xBFFF go to the selected time register when mapping is on. Otherwise they go to RAM (ram_cs, with ram_we on writes) when access is on. Otherwise reads return 0xFF and writes change nothing.
- R7: The time registers are indexed 0 = seconds, 1 = minutes, 2 = hours, 3 = day count bits 7:0, 4 = {kept bits 7:4, upper day count bits in the low bits}. A mapped write stores the whole byte.
- R8: A control write of 0x01 in 0x6000-0x7FFF copies the running counter into the time registers only when the previous write in that window was 0x00. Later ticks do not change the copied values.
- R9: Each tick adds one second. Seconds wrap at 60 into minutes, minutes wrap at 60 into hours, and hours wrap at 24 into the day count.
- R10: rom_cs is high only for reads in 0x0000-0x7FFF. Control writes never assert rom_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| rtc_tick | input | 1 | One-second advance pulse |
| bus_rdata | output | 8 | Read data for the external window, 0xFF elsewhere |
| rom_addr | output | ROM_BANK_BITS+14 | Bank-extended program ROM address |
| rom_cs | output | 1 | Program ROM select |
| ram_addr | output | RAM_BANK_BITS+13 | Bank-extended external RAM address |
| ram_wdata | output | 8 | External RAM write data |
| ram_cs | output | 1 | External RAM select |
| ram_we | output | 1 | External RAM write enable |
| ram_rdata | input | 8 | External RAM read data |

## Verification
Bank writes cover a zero value, a value with bit 7 set whose low bits are zero, an ordinary value and an all-ones value above the configured bank count. These show apart the zero-to-one fix-up, the 7-bit field cut and the output mask. Select-window writes span below 4, 4, 0x08, 0x0C, 0x0D and 0x0F, which separates RAM bank choice, register choice and ignored values. The counter is ticked through a full day plus one hour, minute and second, so all three wrap points are tested at once. The copy sequence is tried both without and with the arming write.

// File: rtl/cart_pkg.sv
package cart_pkg;

  typedef enum logic [1:0] {
    WIN_RAMEN  = 2'd0,
    WIN_ROMSEL = 2'd1,
    WIN_EXTSEL = 2'd2,
    WIN_COPY   = 2'd3
  } ctrl_win_e;

  // program bank fix-up: keep 7 bits, never zero
  function automatic logic [6:0] fix_rom_bank(input logic [7:0] d);
    return (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
  endfunction

  // modulo increment, returns {carry, next}
  function automatic logic [6:0] step_mod(input logic [5:0] v, input logic [5:0] lim);
    if (v == lim - 6'd1) return {1'b1, 6'd0};
    return {1'b0, v + 6'd1};
  endfunction

endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
  import cart_pkg::*;
#(
  parameter int RAM_BANK_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  ctrl_win_e                win,
  input  logic [7:0]               wdata,
  output logic                     ram_en,
  output logic [6:0]               rom_bank,
  output logic [RAM_BANK_BITS-1:0] ram_bank,
  output logic                     clk_map,
  output logic [2:0]               clk_sel,
  output logic                     copy_pulse
);

  localparam logic [7:0] RAM_LIM = 8'(1 << RAM_BANK_BITS);

  logic armed;
  logic sel_ram, sel_clk;

  assign sel_ram    = (wdata < RAM_LIM);
  assign sel_clk    = (wdata >= 8'h08) && (wdata <= 8'h0C);
  assign copy_pulse = wr_en && (win == WIN_COPY) && (wdata == 8'h01) && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en   <= 1'b0;
      rom_bank <= 7'd1;
      ram_bank <= '0;
      clk_map  <= 1'b0;
      clk_sel  <= 3'd0;
      armed    <= 1'b0;
    end else if (wr_en) begin
      case (win)
        WIN_RAMEN: begin
          if (wdata == 8'h0A)      ram_en <= 1'b1;
          else if (wdata == 8'h00) ram_en <= 1'b0;
        end
        WIN_ROMSEL: rom_bank <= fix_rom_bank(wdata);
        WIN_EXTSEL: begin
          if (sel_ram) begin
            ram_bank <= wdata[RAM_BANK_BITS-1:0];
            clk_map  <= 1'b0;
          end else if (sel_clk) begin
            clk_sel  <= wdata[2:0];
            clk_map  <= 1'b1;
          end
        end
        WIN_COPY: armed <= (wdata == 8'h00);
        default: ;
      endcase
    end
  end

  assert_ram_en_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_RAMEN && wdata != 8'h00 && wdata != 8'h0A) |=> $stable(ram_en));

  assert_rom_zero_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_ROMSEL && wdata[6:0] == 7'd0) |=> rom_bank == 7'd1);

  assert_sel_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_EXTSEL && wdata >= RAM_LIM && (wdata < 8'h08 || wdata > 8'h0C))
    |=> ($stable(clk_map) && $stable(clk_sel) && $stable(ram_bank)));

endmodule

// File: rtl/cart_rtc.sv
module cart_rtc
  import cart_pkg::*;
#(
  parameter int DAY_BITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       copy,
  input  logic       wr,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [5:0]          sec, min, hr;
  logic [DAY_BITS-1:0] day;
  logic [6:0]          sec_step, min_step, hr_step;
  logic                sec_wrap, min_wrap, hr_wrap;
  logic [3:0]          day_hi;
  logic [7:0]          l_sec, l_min, l_hr, l_day, l_ctl;

  assign sec_step = step_mod(sec, 6'd60);
  assign min_step = step_mod(min, 6'd60);
  assign hr_step  = step_mod(hr, 6'd24);
  assign sec_wrap = tick && sec_step[6];
  assign min_wrap = sec_wrap && min_step[6];
  assign hr_wrap  = min_wrap && hr_step[6];
  assign day_hi   = 4'(day >> 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0; day <= '0;
    end else if (tick) begin
      sec <= sec_step[5:0];
      if (sec_wrap) min <= min_step[5:0];
      if (min_wrap) hr  <= hr_step[5:0];
      if (hr_wrap)  day <= day + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_sec <= '0; l_min <= '0; l_hr <= '0; l_day <= '0; l_ctl <= '0;
    end else if (copy) begin
      l_sec <= {2'b00, sec};
      l_min <= {2'b00, min};
      l_hr  <= {2'b00, hr};
      l_day <= day[7:0];
      l_ctl <= {l_ctl[7:4], day_hi};
    end else if (wr) begin
      case (sel)
        3'd0: l_sec <= wdata;
        3'd1: l_min <= wdata;
        3'd2: l_hr  <= wdata;
        3'd3: l_day <= wdata;
        3'd4: l_ctl <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      3'd0: rdata = l_sec;
      3'd1: rdata = l_min;
      3'd2: rdata = l_hr;
      3'd3: rdata = l_day;
      3'd4: rdata = l_ctl;
      default: rdata = 8'hFF;
    endcase
  end

  assert_time_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec < 6'd60) && (min < 6'd60) && (hr < 6'd24));

  assert_copy_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> (l_sec == {2'b00, $past(sec)}));

  assert_ctl_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> (l_ctl[7:4] == $past(l_ctl[7:4])));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int ROM_BANK_BITS = 5,
  parameter int RAM_BANK_BITS = 2,
  parameter int DAY_BITS      = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 bus_addr,
  input  logic [7:0]                  bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic                        rtc_tick,
  output logic [7:0]                  bus_rdata,
  output logic [ROM_BANK_BITS+13:0]   rom_addr,
  output logic                        rom_cs,
  output logic [RAM_BANK_BITS+12:0]   ram_addr,
  output logic [7:0]                  ram_wdata,
  output logic                        ram_cs,
  output logic                        ram_we,
  input  logic [7:0]                  ram_rdata
);

  localparam int         ROM_AW   = ROM_BANK_BITS + 14;
  localparam logic [6:0] ROM_MASK = 7'((1 << ROM_BANK_BITS) - 1);

  logic                     in_rom, in_ext, ctrl_wr;
  logic                     ram_en, clk_map, copy_pulse;
  logic [6:0]               rom_bank, eff_bank;
  logic [RAM_BANK_BITS-1:0] ram_bank;
  logic [2:0]               clk_sel;
  logic                     ext_to_clk, ext_to_ram, rtc_wr;
  logic [7:0]               rtc_rdata;

  assign in_rom  = ~bus_addr[15];
  assign in_ext  = (bus_addr[15:13] == 3'b101);
  assign ctrl_wr = bus_wr && in_rom;

  cart_ctrl_regs #(.RAM_BANK_BITS(RAM_BANK_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr),
    .win        (ctrl_win_e'(bus_addr[14:13])),
    .wdata      (bus_wdata),
    .ram_en     (ram_en),
    .rom_bank   (rom_bank),
    .ram_bank   (ram_bank),
    .clk_map    (clk_map),
    .clk_sel    (clk_sel),
    .copy_pulse (copy_pulse)
  );

  assign ext_to_clk = in_ext && clk_map;
  assign ext_to_ram = in_ext && !clk_map && ram_en;
  assign rtc_wr     = ext_to_clk && bus_wr;

  cart_rtc #(.DAY_BITS(DAY_BITS)) u_rtc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (rtc_tick),
    .copy  (copy_pulse),
    .wr    (rtc_wr),
    .sel   (clk_sel),
    .wdata (bus_wdata),
    .rdata (rtc_rdata)
  );

  assign eff_bank  = bus_addr[14] ? (rom_bank & ROM_MASK) : 7'd0;
  assign rom_addr  = ROM_AW'({eff_bank, bus_addr[13:0]});
  assign rom_cs    = bus_rd && in_rom;
  assign ram_addr  = {ram_bank, bus_addr[12:0]};
  assign ram_wdata = bus_wdata;
  assign ram_cs    = ext_to_ram && (bus_rd || bus_wr);
  assign ram_we    = ext_to_ram && bus_wr;

  always_comb begin
    if (bus_rd && ext_to_clk)      bus_rdata = rtc_rdata;
    else if (bus_rd && ext_to_ram) bus_rdata = ram_rdata;
    else                           bus_rdata = 8'hFF;
  end

  assert_ext_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_ext && !ram_cs && !clk_map) |-> bus_rdata == 8'hFF);

  assert_map_blocks_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_ext && clk_map) |-> !ram_we);

  assert_no_rom_cs_on_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd) |-> !rom_cs);

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, rtc_tick = 1'b0;
  logic [7:0]  bus_rdata, ram_wdata, ram_rdata;
  logic [18:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_cs, ram_cs, ram_we;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign ram_rdata = ram_addr[7:0] ^ 8'h3C;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rtc_tick(rtc_tick), .bus_rdata(bus_rdata),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // write with outputs sampled while the strobe is high
  task automatic bus_write_peek(input logic [15:0] a, input logic [7:0] d,
                                output logic we, output logic rcs);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1; we = ram_we; rcs = rom_cs;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
  endtask

  task automatic read_done();
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    bus_read(16'h4000);
    check("R1 rom bank 1", rom_addr, 19'h04000);
    read_done();
    bus_read(16'hA000);
    check("R1 ram off data", bus_rdata, 8'hFF);
    check("R1 ram off cs", ram_cs, 0);
    read_done();
  endtask

  task automatic t_ram_enable();
    bus_write(16'h0000, 8'h0A);
    bus_read(16'hA123);
    check("R2 enabled cs", ram_cs, 1);
    check("R2 enabled data", bus_rdata, 8'h23 ^ 8'h3C);
    check("R4 bank0 addr", ram_addr, 15'h0123);
    read_done();
    bus_write(16'h1FFF, 8'h55);
    bus_read(16'hA000);
    check("R2 other value keeps on", ram_cs, 1);
    read_done();
    bus_write(16'h0000, 8'h00);
    bus_read(16'hA000);
    check("R2 disabled data", bus_rdata, 8'hFF);
    read_done();
    bus_write(16'h0000, 8'h05);
    bus_read(16'hA000);
    check("R2 other value keeps off", ram_cs, 0);
    read_done();
    bus_write(16'h0000, 8'h0A);
  endtask

  task automatic t_rom_bank();
    logic we, rcs;
    bus_write(16'h2000, 8'h00);
    bus_read(16'h5ABC);
    check("R3 zero forced to 1", rom_addr, {5'd1, 14'h1ABC});
    check("R10 rom_cs on read", rom_cs, 1);
    read_done();
    bus_write(16'h3000, 8'h13);
    bus_read(16'h7FFF);
    check("R3 bank 0x13", rom_addr, {5'h13, 14'h3FFF});
    read_done();
    bus_write(16'h2000, 8'h80);
    bus_read(16'h4001);
    check("R3 bit7 only forced to 1", rom_addr, {5'd1, 14'h0001});
    read_done();
    bus_write_peek(16'h2000, 8'h7F, we, rcs);
    check("R10 no rom_cs on control write", rcs, 0);
    bus_read(16'h4000);
    check("R3 masked bank", rom_addr, {5'h1F, 14'h0000});
    read_done();
    bus_read(16'h1234);
    check("R3 fixed window bank 0", rom_addr, 19'h01234);
    read_done();
  endtask

  task automatic t_ram_bank();
    bus_write(16'h4000, 8'h03);
    bus_read(16'hB456);
    check("R4 bank 3 addr", ram_addr, 15'h7456);
    read_done();
    bus_write(16'h4000, 8'h04);
    bus_write(16'h5000, 8'h0D);
    bus_read(16'hB456);
    check("R5 ignored values keep bank", ram_addr, 15'h7456);
    check("R5 ignored values keep ram", ram_cs, 1);
    read_done();
  endtask

  task automatic t_clock_map();
    logic we, rcs;
    bus_write(16'h4000, 8'h08);
    bus_write_peek(16'hA000, 8'h2A, we, rcs);
    check("R6 mapped write not to ram", we, 0);
    bus_read(16'hA000);
    check("R7 seconds reg written", bus_rdata, 8'h2A);
    check("R6 mapped read no ram_cs", ram_cs, 0);
    read_done();
    bus_write(16'h4000, 8'h0C);
    bus_write(16'hBFFF, 8'hA5);
    bus_write(16'h4000, 8'h0F);
    bus_read(16'hA000);
    check("R5 0x0F ignored, reg4 kept", bus_rdata, 8'hA5);
    read_done();
    bus_write(16'h4000, 8'h01);
    bus_read(16'hA010);
    check("R4 map off, ram bank 1", ram_addr, 15'h2010);
    check("R4 map off ram data", bus_rdata, 8'h10 ^ 8'h3C);
    read_done();
    bus_write(16'h0000, 8'h00);
    bus_write_peek(16'hA000, 8'h77, we, rcs);
    check("R6 dropped write", we, 0);
    bus_read(16'hA000);
    check("R6 neither path reads FF", bus_rdata, 8'hFF);
    read_done();
    bus_write(16'h4000, 8'h08);
    bus_read(16'hA000);
    check("R6 dropped write left regs", bus_rdata, 8'h2A);
    read_done();
  endtask

  task automatic t_time_copy();
    @(negedge clk);
    rtc_tick = 1'b1;
    repeat (86400 + 3661) @(negedge clk);
    rtc_tick = 1'b0;
    bus_write(16'h6000, 8'h01);
    bus_read(16'hA000);
    check("R8 unarmed copy has no effect", bus_rdata, 8'h2A);
    read_done();
    bus_write(16'h6000, 8'h00);
    bus_write(16'h7000, 8'h01);
    bus_read(16'hA000);
    check("R9 seconds after wrap", bus_rdata, 8'd1);
    read_done();
    bus_write(16'h4000, 8'h09);
    bus_read(16'hA000);
    check("R9 minutes after wrap", bus_rdata, 8'd1);
    read_done();
    bus_write(16'h4000, 8'h0A);
    bus_read(16'hA000);
    check("R9 hours wrap at 24", bus_rdata, 8'd1);
    read_done();
    bus_write(16'h4000, 8'h0B);
    bus_read(16'hA000);
    check("R9 day count", bus_rdata, 8'd1);
    read_done();
    bus_write(16'h4000, 8'h0C);
    bus_read(16'hA000);
    check("R7 reg4 upper nibble kept", bus_rdata, 8'hA0);
    read_done();
    @(negedge clk);
    rtc_tick = 1'b1;
    repeat (5) @(negedge clk);
    rtc_tick = 1'b0;
    bus_write(16'h4000, 8'h08);
    bus_read(16'hA000);
    check("R8 copied value holds", bus_rdata, 8'd1);
    read_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram_enable();
    t_rom_bank();
    t_ram_bank();
    t_clock_map();
    t_time_copy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL timeout R1 actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule